// File: doc/BRIEF.md
# Selectable Configuration Item Read Port

This block gives a host read access to a fixed set of byte-array configuration items through two registers. The host first writes a 16-bit selector key to a control register. It then reads the chosen item through a data register. Each data read returns 1 to 8 bytes, and an internal byte offset moves forward by the number of bytes actually taken from the item. The keys fall into two planes: a generic plane and an architecture-local plane. Bit 15 of the key chooses the plane, and bits 14:0 give the entry index inside that plane.

The item contents and lengths are not stored as a table. They are computed from the plane, the index and the byte offset, so both stay parameterised and cost almost no storage. A wide read packs item bytes most significant first, in the order the item stores them. If the item ends partway through an access, the remaining low-order byte positions are filled with zeros. Requests arrive on a valid/ready port, and every accepted request gets one response one cycle later.

Top module: `cfg_item_port`

## Requirements
- R1: After reset, key 0 is selected with offset 0 and `sel_ok` is 1, so the first data read returns the first bytes of generic entry 0.
- R2: A control write (`req_write`=1, `req_addr`=0, `req_size`=2) loads the key from `req_wdata` and always sets the offset to zero. Key bit 15 selects the architecture-local plane (1) or the generic plane (0). Bits 14:0 are the entry index.
- R3: If the entry index is at or above MAX_ENTRY (default 8), `sel_ok` becomes 0 and every later data read returns zero until a valid key is written.
- R4: Entry i has length 2*i+3+4*p bytes, where p is the plane bit. The exception is generic entry EMPTY_IDX (default 2), which has no data. Byte k of an item is (128*p + 16*i + k) mod 256.
- R5: A data read (`req_write`=0, `req_addr`=1) of N bytes, with N from 1 to 8, returns the N next item bytes in `rsp_rdata[8N-1:0]`. The first byte sits in the most significant position. Bits above 8N are zero.
- R6: When fewer than N bytes remain, the remaining bytes fill the high positions, the low positions are zero, and the offset stops at the item length.
- R7: A read with the offset at or past the item length, or a read of an entry that has no data, returns zero and leaves the offset unchanged.
- R8: Each byte taken by a data read advances the offset by exactly one, so consecutive reads continue the byte stream without gaps.
- R9: Any other access gets `rsp_err`=1 and `rsp_rdata`=0 and changes neither the key nor the offset. This covers data reads of size 0 or above 8, control accesses that are not 2-byte writes, and data writes.
- R10: `req_ready` is always 1. Each accepted request produces `rsp_valid`=1 in the next cycle only, and in no other cycle is `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = control register, 1 = data register |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 16 | Selector key for control writes |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Packed read data (8*LANES bits) |
| sel_ok | output | 1 | The current key addresses an existing entry |

## Verification
Every result of this block is due exactly one clock edge after its request is accepted. That holds for the response flag, the read data, the error flag and the `sel_ok` status that follows a select. The offset effect of a read shows up in the data of the next read, one request later. The bench drives each request on a falling edge. It samples all outputs on the next falling edge, after the single registering edge. On the falling edge after that it checks that `rsp_valid` has dropped again. Expected bytes come from a bench-side model of the key and offset that follows the length and content formulas of R4.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

   // Length in bytes of entry idx in plane p; empty_idx marks the data-less generic entry
   function automatic int item_len_f(input logic p, input int idx, input int empty_idx);
      if (!p && idx == empty_idx) return 0;
      return 2 * idx + 3 + (p ? 4 : 0);
   endfunction

   // Content of byte k of entry idx in plane p
   function automatic logic [7:0] item_byte_f(input logic p, input int idx, input int k);
      int v;
      v = (p ? 128 : 0) + 16 * idx + k;
      return 8'(v);
   endfunction

   typedef enum logic [1:0] {
      ACC_SELECT = 2'd0,
      ACC_READ   = 2'd1,
      ACC_REJECT = 2'd2
   } acc_kind_t;

endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom #(
   parameter int LANES     = 8,
   parameter int OFS_W     = 8,
   parameter int ENT_W     = 3,
   parameter int EMPTY_IDX = 2
) (
   input  logic                 plane,
   input  logic [ENT_W-1:0]     idx,
   input  logic [OFS_W-1:0]     base_ofs,
   output logic [OFS_W-1:0]     item_len,
   output logic [8*LANES-1:0]   lane_bytes
);
   import cfg_item_pkg::*;

   assign item_len = OFS_W'(item_len_f(plane, int'(idx), EMPTY_IDX));

   // One computed lane per byte of the widest access
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_bytes[8*k +: 8] = item_byte_f(plane, int'(idx), int'(base_ofs) + k);
   end

endmodule

// File: rtl/cfg_item_sel.sv
module cfg_item_sel #(
   parameter int KEY_W     = 16,
   parameter int ARCH_BIT  = 15,
   parameter int MAX_ENTRY = 8,
   parameter int ENT_W     = 3,
   parameter int OFS_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_we,
   input  logic [KEY_W-1:0]   sel_key,
   input  logic               adv_en,
   input  logic [3:0]         adv_cnt,
   output logic               cur_plane,
   output logic [ENT_W-1:0]   cur_idx,
   output logic               cur_valid,
   output logic [OFS_W-1:0]   cur_ofs
);
   localparam int IDX_W = KEY_W - 1;

   logic [IDX_W-1:0] key_idx;
   logic             key_in_range;

   // Index field is every key bit except the plane bit
   for (genvar b = 0; b < KEY_W; b++) begin : g_strip
      if (b < ARCH_BIT) begin : g_lo
         assign key_idx[b] = sel_key[b];
      end else if (b > ARCH_BIT) begin : g_hi
         assign key_idx[b-1] = sel_key[b];
      end
   end

   // Range check: power-of-two counts reduce to a zero test on the upper bits
   if ((MAX_ENTRY & (MAX_ENTRY - 1)) == 0 && ENT_W < IDX_W) begin : g_pow2
      assign key_in_range = ~|key_idx[IDX_W-1:ENT_W];
   end else begin : g_cmp
      assign key_in_range = (key_idx < IDX_W'(MAX_ENTRY));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_plane <= 1'b0;
         cur_idx   <= '0;
         cur_valid <= 1'b1;
         cur_ofs   <= '0;
      end else if (sel_we) begin
         cur_plane <= sel_key[ARCH_BIT];
         cur_idx   <= key_idx[ENT_W-1:0];
         cur_valid <= key_in_range;
         cur_ofs   <= '0;
      end else if (adv_en) begin
         cur_ofs   <= cur_ofs + OFS_W'(adv_cnt);
      end
   end

endmodule

// File: rtl/cfg_item_pack.sv
module cfg_item_pack #(
   parameter int LANES = 8,
   parameter int OFS_W = 8
) (
   input  logic                 sel_valid,
   input  logic [OFS_W-1:0]     item_len,
   input  logic [OFS_W-1:0]     cur_ofs,
   input  logic [3:0]           rd_size,
   input  logic [8*LANES-1:0]   lane_bytes,
   output logic [8*LANES-1:0]   rd_data,
   output logic [3:0]           take_cnt
);
   logic [OFS_W-1:0] avail;

   always_comb begin
      if (sel_valid && item_len > cur_ofs) avail = item_len - cur_ofs;
      else                                 avail = '0;
      if (avail < OFS_W'(rd_size)) take_cnt = avail[3:0];
      else                         take_cnt = rd_size;
   end

   // Output byte p (p=0 least significant) carries lane size-1-p
   for (genvar p = 0; p < LANES; p++) begin : g_pos
      int lane;
      always_comb begin
         lane = int'(rd_size) - 1 - p;
         if (lane >= 0 && lane < int'(take_cnt))
            rd_data[8*p +: 8] = lane_bytes[8*lane +: 8];
         else
            rd_data[8*p +: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port #(
   parameter int KEY_W     = 16,
   parameter int ARCH_BIT  = 15,
   parameter int MAX_ENTRY = 8,
   parameter int EMPTY_IDX = 2,
   parameter int LANES     = 8,
   parameter int OFS_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic                 req_addr,
   input  logic [3:0]           req_size,
   input  logic [KEY_W-1:0]     req_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [8*LANES-1:0]   rsp_rdata,
   output logic                 sel_ok
);
   import cfg_item_pkg::*;

   localparam int ENT_W   = (MAX_ENTRY > 1) ? $clog2(MAX_ENTRY) : 1;
   localparam int MAX_LEN = 2 * MAX_ENTRY + 7;

   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("LANES must lie in 1..8");
   end
   if (ARCH_BIT < 0 || ARCH_BIT >= KEY_W) begin : g_bad_arch
      $error("ARCH_BIT must lie inside the key");
   end
   if (OFS_W < 4 || MAX_LEN + LANES >= (1 << OFS_W)) begin : g_bad_ofs
      $error("OFS_W too narrow for the item lengths");
   end
   if (ENT_W >= KEY_W - 1) begin : g_bad_ent
      $error("MAX_ENTRY too large for the key index field");
   end

   logic               acc;
   acc_kind_t          kind;
   logic               cur_plane;
   logic [ENT_W-1:0]   cur_idx;
   logic               cur_valid;
   logic [OFS_W-1:0]   cur_ofs;
   logic [OFS_W-1:0]   item_len;
   logic [8*LANES-1:0] lane_bytes;
   logic [8*LANES-1:0] pack_data;
   logic [3:0]         take_cnt;

   assign req_ready = 1'b1;
   assign acc       = req_valid & req_ready;

   always_comb begin
      if (req_write && !req_addr && req_size == 4'd2)
         kind = ACC_SELECT;
      else if (!req_write && req_addr && req_size != 4'd0 && req_size <= 4'(LANES))
         kind = ACC_READ;
      else
         kind = ACC_REJECT;
   end

   cfg_item_sel #(
      .KEY_W(KEY_W), .ARCH_BIT(ARCH_BIT), .MAX_ENTRY(MAX_ENTRY),
      .ENT_W(ENT_W), .OFS_W(OFS_W)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_we    (acc && kind == ACC_SELECT),
      .sel_key   (req_wdata),
      .adv_en    (acc && kind == ACC_READ),
      .adv_cnt   (take_cnt),
      .cur_plane (cur_plane),
      .cur_idx   (cur_idx),
      .cur_valid (cur_valid),
      .cur_ofs   (cur_ofs)
   );

   cfg_item_rom #(
      .LANES(LANES), .OFS_W(OFS_W), .ENT_W(ENT_W), .EMPTY_IDX(EMPTY_IDX)
   ) u_rom (
      .plane      (cur_plane),
      .idx        (cur_idx),
      .base_ofs   (cur_ofs),
      .item_len   (item_len),
      .lane_bytes (lane_bytes)
   );

   cfg_item_pack #(
      .LANES(LANES), .OFS_W(OFS_W)
   ) u_pack (
      .sel_valid  (cur_valid),
      .item_len   (item_len),
      .cur_ofs    (cur_ofs),
      .rd_size    (req_size),
      .lane_bytes (lane_bytes),
      .rd_data    (pack_data),
      .take_cnt   (take_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= acc;
         rsp_err   <= acc && kind == ACC_REJECT;
         rsp_rdata <= (acc && kind == ACC_READ) ? pack_data : '0;
      end
   end

   assign sel_ok = cur_valid;

endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
   parameter int LANES = 8,
   parameter int OFS_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               req_write,
   input logic               req_addr,
   input logic [3:0]         req_size,
   input logic               rsp_valid,
   input logic               rsp_err,
   input logic [8*LANES-1:0] rsp_rdata,
   input logic               sel_ok,
   input logic [OFS_W-1:0]   cur_ofs,
   input logic [OFS_W-1:0]   item_len
);
   logic take, good_sel, good_rd, bad_acc;
   assign take     = req_valid && req_ready;
   assign good_sel = take && req_write && !req_addr && req_size == 4'd2;
   assign good_rd  = take && !req_write && req_addr && req_size >= 4'd1 && req_size <= 4'(LANES);
   assign bad_acc  = take && !good_sel && !good_rd;

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> rsp_valid);                                            // R10
   AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !rsp_valid);                                          // R10
   AST_SEL_CLEARS_OFS: assert property (@(posedge clk) disable iff (!rst_n)
      good_sel |=> cur_ofs == '0);                                    // R2
   AST_OFS_IN_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ok |-> cur_ofs <= item_len);                                // R6
   AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      bad_acc |=> rsp_err && $stable(cur_ofs) && $stable(sel_ok));    // R9
   AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (good_rd && !sel_ok) |=> rsp_rdata == '0);                      // R3
   AST_READ_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      good_rd |=> cur_ofs >= $past(cur_ofs));                         // R8

endmodule

bind cfg_item_port cfg_item_port_chk #(.LANES(LANES), .OFS_W(OFS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_size  (req_size),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .sel_ok    (sel_ok),
   .cur_ofs   (cur_ofs),
   .item_len  (item_len)
);

// File: tb/cfg_item_port_test.sv
module cfg_item_port_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_addr = 1'b0;
   logic [3:0]  req_size = 4'd0;
   logic [15:0] req_wdata = 16'h0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [63:0] rsp_rdata;
   logic        sel_ok;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Bench model of the selection
   logic [15:0] m_key = 16'h0;
   int          m_ofs = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_item_port uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .sel_ok(sel_ok)
   );

   function automatic bit m_valid();
      return int'(m_key[14:0]) < 8;
   endfunction

   function automatic int m_len();
      int i;
      i = int'(m_key[14:0]);
      if (!m_key[15] && i == 2) return 0;
      return 2 * i + 3 + (m_key[15] ? 4 : 0);
   endfunction

   function automatic logic [7:0] m_byte(input int k);
      return 8'((m_key[15] ? 128 : 0) + 16 * int'(m_key[14:0]) + k);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One request; response sampled on the falling edge after the registering edge
   task automatic do_req(input bit wr, input bit addr, input logic [3:0] size,
                         input logic [15:0] wdata, input bit exp_err,
                         input logic [63:0] exp_data, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = wdata;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid === 1'b1, "R10 rsp_valid", {63'd0, rsp_valid}, 64'd1);
      check(rsp_err === exp_err, {req, " rsp_err"}, {63'd0, rsp_err}, {63'd0, exp_err});
      check(rsp_rdata === exp_data, {req, " rdata"}, rsp_rdata, exp_data);
      @(negedge clk);
      check(rsp_valid === 1'b0, "R10 idle", {63'd0, rsp_valid}, 64'd0);
   endtask

   task automatic sel(input logic [15:0] key, input string req);
      m_key = key; m_ofs = 0;
      do_req(1'b1, 1'b0, 4'd2, key, 1'b0, 64'd0, req);
      check(sel_ok === m_valid(), {req, " sel_ok"}, {63'd0, sel_ok}, {63'd0, m_valid()});
   endtask

   task automatic rd(input int n, input string req);
      logic [63:0] v;
      v = 64'd0;
      for (int p = 0; p < n; p++) begin
         if (m_valid() && m_ofs < m_len()) begin
            v = (v << 8) | {56'd0, m_byte(m_ofs)};
            m_ofs++;
         end else begin
            v = v << 8;
         end
      end
      do_req(1'b0, 1'b1, 4'(n), 16'h0, 1'b0, v, req);
   endtask

   task automatic t_reset();
      check(sel_ok === 1'b1, "R1 reset sel_ok", {63'd0, sel_ok}, 64'd1);
      check(rsp_valid === 1'b0, "R10 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
      rd(4, "R1 R5 R6 reset read");               // 00 01 02 + pad
   endtask

   task automatic t_stream();
      sel(16'h0005, "R2 select 5");
      rd(1, "R8 byte 0");
      rd(1, "R8 byte 1");
      rd(1, "R8 byte 2");
      rd(8, "R5 wide read");
      rd(3, "R6 tail pad");
      rd(2, "R7 past end");
      sel(16'h0005, "R2 reselect");
      rd(2, "R2 offset restart");
   endtask

   task automatic t_arch();
      sel(16'h8001, "R2 local plane");
      rd(8, "R4 local content");
      rd(5, "R6 local tail");
      sel(16'h8002, "R4 local twin of empty");
      rd(1, "R4 local entry 2");
   endtask

   task automatic t_invalid();
      sel(16'h0008, "R3 index at limit");
      rd(8, "R3 invalid read");
      sel(16'h8009, "R3 local out of range");
      rd(4, "R3 invalid local read");
      sel(16'h0007, "R3 last valid");
      rd(6, "R4 last entry");
   endtask

   task automatic t_empty();
      sel(16'h0002, "R7 empty select");
      rd(4, "R7 empty read");
      rd(1, "R7 empty again");
   endtask

   task automatic t_errors();
      sel(16'h0003, "R9 setup");
      rd(1, "R9 first byte");
      do_req(1'b0, 1'b1, 4'd0, 16'h0, 1'b1, 64'd0, "R9 size zero");
      do_req(1'b0, 1'b1, 4'd9, 16'h0, 1'b1, 64'd0, "R9 size nine");
      do_req(1'b1, 1'b0, 4'd1, 16'h0001, 1'b1, 64'd0, "R9 narrow ctl write");
      do_req(1'b1, 1'b0, 4'd4, 16'h0001, 1'b1, 64'd0, "R9 wide ctl write");
      do_req(1'b0, 1'b0, 4'd2, 16'h0, 1'b1, 64'd0, "R9 ctl read");
      do_req(1'b1, 1'b1, 4'd1, 16'h0, 1'b1, 64'd0, "R9 data write");
      check(sel_ok === 1'b1, "R9 sel kept", {63'd0, sel_ok}, 64'd1);
      rd(2, "R9 offset kept");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1, "R10 ready", {63'd0, req_ready}, 64'd1);
      t_reset();
      t_stream();
      t_arch();
      t_invalid();
      t_empty();
      t_errors();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule